// File: doc/BRIEF.md
# Watchdog Timer with Programmable Prescaler

This block is a watchdog that counts pulses of a free-running base tick and raises a one-cycle reset request when the count reaches a ratio chosen by software. Software holds the ratio code and a run bit in an 8-bit control register. A fixed configuration input can force the watchdog to run whatever the run bit says.

Firmware services the watchdog by pulsing the kick strobe before the period expires. Any write to the control register also restarts the period. Stopping the watchdog holds its count at zero. The ratio is a power of two between 32 and 65536 ticks. Codes above the legal range fall back to the longest period.

Top module: `wdog_prescaled`

## Requirements
- R1: The control register reads as `{3'b000, code[3:0], sw_en}`. Bits 4:1 hold the ratio code and bit 0 is the software run bit. A write stores `wr_data_i[4:0]`, and bits 7:5 always read zero. The register changes only on a write.
- R2: After reset the register reads 0x08, meaning code 4 with the run bit clear.
- R3: With code n from 0 to 11 and the watchdog running, `timeout_o` rises after exactly 2^(n+5) cycles in which `tick_i` was high, counted from the last restart. Cycles with `tick_i` low are not counted.
- R4: Codes 12 to 15 give a period of 65536 ticks. The register still reads back the code that was written.
- R5: While `cfg_force_en_i` is 1 the watchdog runs even when the run bit is 0.
- R6: While `cfg_force_en_i` is 0 the run bit alone starts and stops the watchdog. While stopped, no timeout occurs and the count is zero, so on restart a full period is needed.
- R7: `timeout_o` is high for exactly one cycle, which is the cycle after the terminal tick. The count then starts again from zero, so the next timeout follows after another full period.
- R8: A `kick_i` pulse restarts the period. It takes priority over a tick in the same cycle.
- R9: Any register write restarts the period, including a write of an unchanged value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Base tick, one count per high cycle |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read data |
| cfg_force_en_i | input | 1 | Configuration input that forces the watchdog to run |
| kick_i | input | 1 | Service strobe that restarts the period |
| timeout_o | output | 1 | One-cycle reset request |

## Verification
The assertions assume that reset is applied before any traffic. They also assume that no period is shorter than two ticks, so two timeouts cannot fall in back-to-back cycles. The ratio codes make this hold for every legal setting.

The stimulus drives ticks with a random density from a fixed seed. It uses only the small codes for the random period runs and keeps a single dense run for the longest ratio. Kicks, writes and enable changes are applied at chosen points mid-count. Each of these changes a single input for one cycle between negative edges, so every restart can be attributed to one cause.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W     = 8;
  localparam int CODE_W    = 4;
  localparam int MIN_SHIFT = 5;
  localparam int NUM_CODES = 12;
  localparam int RST_CODE  = 4;
  localparam int CNT_W     = MIN_SHIFT + NUM_CODES - 1;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg #(
  parameter int REG_W    = wdt_pkg::REG_W,
  parameter int CODE_W   = wdt_pkg::CODE_W,
  parameter int RST_CODE = wdt_pkg::RST_CODE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [CODE_W-1:0] code_o,
  output logic              sw_en_o,
  output logic [REG_W-1:0]  rd_data_o
);
  localparam int USED_W = CODE_W + 1;

  logic [CODE_W-1:0] code_q;
  logic              en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CODE_W'(RST_CODE);
      en_q   <= 1'b0;
    end else if (wr_en_i) begin
      code_q <= wr_data_i[CODE_W:1];
      en_q   <= wr_data_i[0];
    end
  end

  assign code_o    = code_q;
  assign sw_en_o   = en_q;
  assign rd_data_o = {{(REG_W-USED_W){1'b0}}, code_q, en_q};

  p_readback_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == {{(REG_W-USED_W){1'b0}}, $past(wr_data_i[USED_W-1:0])});
  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));
endmodule

// File: rtl/wdt_period_dec.sv
module wdt_period_dec #(
  parameter int CODE_W    = wdt_pkg::CODE_W,
  parameter int MIN_SHIFT = wdt_pkg::MIN_SHIFT,
  parameter int NUM_CODES = wdt_pkg::NUM_CODES,
  parameter int CNT_W     = wdt_pkg::CNT_W
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  term_o
);
  logic [CNT_W-1:0] term_lut [NUM_CODES];

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_term
    assign term_lut[g] = CNT_W'((64'd1 << (MIN_SHIFT + g)) - 64'd1);
  end

  // reserved codes fall back to the longest period
  always_comb begin
    term_o = term_lut[NUM_CODES-1];
    for (int i = 0; i < NUM_CODES; i++) begin
      if (code_i == CODE_W'(i)) term_o = term_lut[i];
    end
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = wdt_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] term_i,
  output logic             timeout_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (clr_i || !en_i) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == term_i) begin
        cnt_q <= '0;
        to_q  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        to_q  <= 1'b0;
      end
    end else begin
      to_q <= 1'b0;
    end
  end

  assign timeout_o = to_q;

  p_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= term_i);
  p_off_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0) && !to_q);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && !to_q);
  p_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_q |=> !to_q);
  p_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    to_q |-> cnt_q == '0);
endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled #(
  parameter int REG_W     = wdt_pkg::REG_W,
  parameter int CODE_W    = wdt_pkg::CODE_W,
  parameter int MIN_SHIFT = wdt_pkg::MIN_SHIFT,
  parameter int NUM_CODES = wdt_pkg::NUM_CODES,
  parameter int RST_CODE  = wdt_pkg::RST_CODE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             cfg_force_en_i,
  input  logic             kick_i,
  output logic             timeout_o
);
  localparam int CNT_W = MIN_SHIFT + NUM_CODES - 1;

  logic [CODE_W-1:0] code;
  logic              sw_en;
  logic [CNT_W-1:0]  term;
  logic              run;

  wdt_ctrl_reg #(.REG_W(REG_W), .CODE_W(CODE_W), .RST_CODE(RST_CODE)) u_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_data_i,
    .code_o(code), .sw_en_o(sw_en), .rd_data_o
  );

  wdt_period_dec #(.CODE_W(CODE_W), .MIN_SHIFT(MIN_SHIFT),
                   .NUM_CODES(NUM_CODES), .CNT_W(CNT_W)) u_dec (
    .code_i(code), .term_o(term)
  );

  // hard configuration input overrides the software run bit
  assign run = cfg_force_en_i | sw_en;

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .en_i(run), .clr_i(kick_i | wr_en_i),
    .tick_i, .term_i(term), .timeout_o
  );

  p_quiet_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_force_en_i && !sw_en) |=> !timeout_o);
endmodule

// File: tb/tb_wdog_prescaled.sv
module tb_wdog_prescaled;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       cfg_force_en_i = 1'b0;
  logic       kick_i = 1'b0;
  logic       timeout_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  wdog_prescaled dut (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 190000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic int ratio_of(int code);
    return (code >= 12) ? 65536 : (32 << code);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // drives ticks until timeout seen; returns ticks applied
  task automatic measure(bit dense, int max, output int ticks);
    bit t;
    ticks = 0;
    forever begin
      if (timeout_o || ticks > max) break;
      t = dense ? 1'b1 : ($urandom % 4 != 0);
      tick_i = t;
      ticks += int'(t);
      @(negedge clk_i);
    end
    tick_i = 1'b0;
  endtask

  // applies n ticks, returns number of timeouts observed
  task automatic run_ticks(int n, output int tos);
    tos = 0;
    for (int i = 0; i < n; i++) begin
      if (timeout_o) tos++;
      tick_i = 1'b1;
      @(negedge clk_i);
    end
    tick_i = 1'b0;
    if (timeout_o) tos++;
  endtask

  initial begin
    int got, tos, code;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    chk(rd_data_o == 8'h08, "R2 reset value", rd_data_o, 8'h08);
    chk(timeout_o == 1'b0, "R2 no timeout at reset", timeout_o, 0);

    wr(8'hFF);
    chk(rd_data_o == 8'h1F, "R1 upper bits read zero", rd_data_o, 8'h1F);
    wr(8'hA6);
    chk(rd_data_o == 8'h06, "R1 readback", rd_data_o, 8'h06);

    // R6: stopped with cfg low, no timeouts
    wr(8'h00);
    run_ticks(200, tos);
    chk(tos == 0, "R6 stopped, no timeout", tos, 0);

    // R3: random codes, sparse random ticks
    for (int k = 0; k < 8; k++) begin
      code = (k < 5) ? k : int'($urandom % 5);
      wr(8'((code << 1) | 1));
      measure(1'b0, 2000, got);
      chk(got == ratio_of(code), "R3 period", got, ratio_of(code));
      @(negedge clk_i);
      chk(timeout_o == 1'b0, "R7 single cycle pulse", timeout_o, 0);
    end

    // R7: restart gives another full period
    wr(8'h01);
    measure(1'b1, 100, got);
    @(negedge clk_i);
    measure(1'b0, 100, got);
    chk(got == 32, "R7 next period", got, 32);

    // R8: kick with coincident tick
    wr(8'h01);
    run_ticks(20, tos);
    @(negedge clk_i);
    kick_i = 1'b1; tick_i = 1'b1;
    @(negedge clk_i);
    kick_i = 1'b0; tick_i = 1'b0;
    measure(1'b0, 100, got);
    chk(got == 32, "R8 kick restarts", got, 32);

    // R9: rewrite of same value
    wr(8'h01);
    run_ticks(25, tos);
    wr(8'h01);
    measure(1'b1, 100, got);
    chk(got == 32, "R9 write restarts", got, 32);

    // R5: forced run with sw bit clear
    wr(8'h00);
    cfg_force_en_i = 1'b1;
    measure(1'b0, 100, got);
    chk(got == 32, "R5 forced run", got, 32);
    @(negedge clk_i);
    // R6: dropping enable mid-count clears the count
    run_ticks(20, tos);
    cfg_force_en_i = 1'b0; tick_i = 1'b1;
    @(negedge clk_i);
    cfg_force_en_i = 1'b1; tick_i = 1'b0;
    measure(1'b1, 100, got);
    chk(got == 32, "R6 restart after stop", got, 32);
    cfg_force_en_i = 1'b0;

    // R4: reserved code
    wr(8'h1B);
    chk(rd_data_o == 8'h1B, "R4 reserved readback", rd_data_o, 8'h1B);
    measure(1'b1, 70000, got);
    chk(got == 65536, "R4 reserved period", got, 65536);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule